// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

The block gathers up to 32 level-sensitive interrupt lines and adds a software-settable pending bit for each one. It gates every source with its own enable bit and sends each enabled source to one of two processor outputs: a normal request line or a fast request line. Software reaches every control and status word through a small register bus. The bus has a read/write select, a privilege flag and a byte address. Read data is combinational, and any side effect of an access takes place on the clock edge that ends it.

For the normal request path the block has sixteen programmable vector slots. Each slot names one source and holds a handler address. A read of the current-vector word returns the address of the best matching slot, and the same read marks that slot as in service. While a slot is in service, only slots of higher priority can be presented. A write of any value to the current-vector word ends the most recent service level. A read-only identification value is spread one byte per word across four words, so that software can recognise the cell.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset every register reads zero, including select, enable, soft, protection, default vector and the current vector. Both irq_o and fiq_o are low.
- R2: Writing ones to 0x010 sets enable bits and writing ones to 0x014 clears them. Zero bits have no effect. A read of 0x010 returns the enable mask.
- R3: Writing ones to 0x018 sets soft bits and writing ones to 0x01C clears them. Zero bits have no effect. A read of 0x018 returns the soft bits.
- R4: A source is active when (line OR soft bit) AND enable bit. Select bit 1 at 0x00C routes it to the fast path and bit 0 routes it to the normal path. 0x000 reads the active normal-path sources and 0x004 the active fast-path sources. irq_o and fiq_o are the OR of each set.
- R5: Slot n has an address word at 0x100+4n and a control word at 0x200+4n. In the control word, bits 4:0 give the source and bit 5 enables the slot. Both words read back what was written; the control word reads back bits 5:0 only.
- R6: A read of 0x030 returns the address of the lowest-numbered enabled slot that is below the service threshold and whose source is active on the normal path. With no such slot the read returns the default address held at 0x034. A fast-path source never matches a slot.
- R7: A matching read of 0x030 puts that slot in service. The threshold is the lowest-numbered slot in service, and only lower-numbered slots can match above it. A read that returns the default changes no service state.
- R8: A write of any value to 0x030 ends service of the lowest-numbered slot in service. With no slot in service it has no effect.
- R9: When bit 0 of the protection word (0x020) is set, writes with bus_priv low are ignored and privileged writes still take effect.
- R10: Word k (k = 0..3) at 0xFE0+4k returns byte k of the cell ID in bits 7:0, counting the least significant byte as byte 0. Its upper bits read zero.
- R11: A write to 0x300 is accepted with no effect. Reads of 0x300, 0x008 and slot words beyond the last slot return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Level-sensitive hardware interrupt lines |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions take the interrupt lines as synchronous to clk, and they take each access as lasting exactly one cycle with bus_wr stable. Under those conditions a set write, a clear write and a protected write each have a defined effect on the next cycle. The service assertions also assume that a vector read and an end-of-service write never occur in the same cycle. The bench keeps to these conditions: it changes src_i and the bus only at falling edges, and it holds each access for a single rising edge. It also pairs every matching vector read with its own end-of-service write, so each service sequence starts from a known state.

// File: rtl/vecirq_pkg.sv
// Package: register offsets and bus widths shared by the interrupt controller.
// Assumes a 12-bit byte address and 32-bit data words, word aligned.
package vecirq_pkg;
    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFF_IRQ_STAT  = 12'h000;
    localparam logic [BUS_AW-1:0] OFF_FIQ_STAT  = 12'h004;
    localparam logic [BUS_AW-1:0] OFF_SELECT    = 12'h00C;
    localparam logic [BUS_AW-1:0] OFF_EN_SET    = 12'h010;
    localparam logic [BUS_AW-1:0] OFF_EN_CLR    = 12'h014;
    localparam logic [BUS_AW-1:0] OFF_SOFT_SET  = 12'h018;
    localparam logic [BUS_AW-1:0] OFF_SOFT_CLR  = 12'h01C;
    localparam logic [BUS_AW-1:0] OFF_PROT      = 12'h020;
    localparam logic [BUS_AW-1:0] OFF_CUR_VEC   = 12'h030;
    localparam logic [BUS_AW-1:0] OFF_DEF_VEC   = 12'h034;
    localparam logic [BUS_AW-1:0] OFF_SLOT_ADDR = 12'h100;
    localparam logic [BUS_AW-1:0] OFF_SLOT_CTRL = 12'h200;
    localparam logic [BUS_AW-1:0] OFF_TEST      = 12'h300;
    localparam logic [BUS_AW-1:0] OFF_ID        = 12'hFE0;
endpackage

// File: rtl/vecirq_regs.sv
// Module: writable register file of the interrupt controller.
// Holds routing, enable, soft, protection, default vector and slot words.
// Assumes NSRC <= 32, NSLOT <= 64, VAW <= 32; accesses are one cycle long.
module vecirq_regs
    import vecirq_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned VAW   = 32,
    localparam int unsigned SELW = $clog2(NSRC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic                           bus_priv,
    input  logic [BUS_AW-1:0]              bus_addr,
    input  logic [BUS_DW-1:0]              bus_wdata,
    output logic [NSRC-1:0]                sel_q,
    output logic [NSRC-1:0]                en_q,
    output logic [NSRC-1:0]                soft_q,
    output logic                           prot_q,
    output logic [VAW-1:0]                 def_q,
    output logic [NSLOT-1:0][VAW-1:0]      slot_addr_q,
    output logic [NSLOT-1:0][SELW:0]       slot_ctrl_q,
    output logic                           vec_rd,
    output logic                           vec_ack
);
    logic wr_ok;

    // Accept a write unless protection is on and the access is not privileged.
    assign wr_ok   = bus_sel && bus_wr && (!prot_q || bus_priv);
    // Strobes for the current-vector word: read claims, write releases.
    assign vec_rd  = bus_sel && !bus_wr && (bus_addr == OFF_CUR_VEC);
    assign vec_ack = wr_ok && (bus_addr == OFF_CUR_VEC);

    // Routing select word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_ok && bus_addr == OFF_SELECT)
            sel_q <= bus_wdata[NSRC-1:0];
    end

    // Enable mask with separate set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_ok && bus_addr == OFF_EN_SET)
            en_q <= en_q | bus_wdata[NSRC-1:0];
        else if (wr_ok && bus_addr == OFF_EN_CLR)
            en_q <= en_q & ~bus_wdata[NSRC-1:0];
    end

    // Software pending bits with separate set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            soft_q <= '0;
        else if (wr_ok && bus_addr == OFF_SOFT_SET)
            soft_q <= soft_q | bus_wdata[NSRC-1:0];
        else if (wr_ok && bus_addr == OFF_SOFT_CLR)
            soft_q <= soft_q & ~bus_wdata[NSRC-1:0];
    end

    // Protection enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= 1'b0;
        else if (wr_ok && bus_addr == OFF_PROT)
            prot_q <= bus_wdata[0];
    end

    // Default vector address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            def_q <= '0;
        else if (wr_ok && bus_addr == OFF_DEF_VEC)
            def_q <= bus_wdata[VAW-1:0];
    end

    // One address and one control word per vector slot.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic hit_addr;
        logic hit_ctrl;
        assign hit_addr = wr_ok && (bus_addr[11:8] == OFF_SLOT_ADDR[11:8])
                          && (bus_addr[7:2] == 6'(g)) && (bus_addr[1:0] == 2'b00);
        assign hit_ctrl = wr_ok && (bus_addr[11:8] == OFF_SLOT_CTRL[11:8])
                          && (bus_addr[7:2] == 6'(g)) && (bus_addr[1:0] == 2'b00);

        // Slot handler address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_addr_q[g] <= '0;
            else if (hit_addr)
                slot_addr_q[g] <= bus_wdata[VAW-1:0];
        end

        // Slot enable and source select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_ctrl_q[g] <= '0;
            else if (hit_ctrl)
                slot_ctrl_q[g] <= bus_wdata[SELW:0];
        end
    end
endmodule

// File: rtl/vecirq_route.sv
// Module: combines lines with soft bits, applies enables and splits by select.
// Assumes src_i is already synchronous to the controller clock.
module vecirq_route #(
    parameter int unsigned NSRC = 32
) (
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] soft_q,
    input  logic [NSRC-1:0] en_q,
    input  logic [NSRC-1:0] sel_q,
    output logic [NSRC-1:0] irq_stat,
    output logic [NSRC-1:0] fiq_stat
);
    logic [NSRC-1:0] active;

    // Per-source active level after masking.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign active[g]   = (src_i[g] | soft_q[g]) & en_q[g];
        assign irq_stat[g] = active[g] & ~sel_q[g];
        assign fiq_stat[g] = active[g] &  sel_q[g];
    end
endmodule

// File: rtl/vecirq_prio.sv
// Module: vector slot matching, priority pick and service nesting.
// Lower slot numbers win. Service state is a bit per slot; the lowest set
// bit is the threshold. Assumes vec_rd and vec_ack are never both high.
module vecirq_prio #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned VAW   = 32,
    localparam int unsigned SELW = $clog2(NSRC),
    localparam int unsigned SIW  = $clog2(NSLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           irq_stat,
    input  logic [NSLOT-1:0][VAW-1:0] slot_addr_q,
    input  logic [NSLOT-1:0][SELW:0]  slot_ctrl_q,
    input  logic [VAW-1:0]            def_q,
    input  logic                      vec_rd,
    input  logic                      vec_ack,
    output logic [VAW-1:0]            cur_vec,
    output logic                      hit_any,
    output logic [NSLOT-1:0]          svc_q
);
    logic [NSLOT-1:0] slot_hit;
    logic [NSLOT-1:0] svc_upto;
    logic [NSLOT-1:0] cand;
    logic [SIW-1:0]   win;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Slot requests when enabled and its source is active on the normal path.
        assign slot_hit[g] = slot_ctrl_q[g][SELW] & irq_stat[slot_ctrl_q[g][SELW-1:0]];
        // Running OR of service bits from slot 0 up to this slot.
        if (g == 0) begin : g_first
            assign svc_upto[g] = svc_q[g];
        end else begin : g_rest
            assign svc_upto[g] = svc_upto[g-1] | svc_q[g];
        end
        // A slot may present only if no slot at or above its priority is in service.
        assign cand[g] = slot_hit[g] & ~svc_upto[g];
    end

    // Pick the lowest-numbered candidate.
    always_comb begin
        win     = '0;
        hit_any = 1'b0;
        for (int n = NSLOT - 1; n >= 0; n--) begin
            if (cand[n]) begin
                win     = SIW'(n);
                hit_any = 1'b1;
            end
        end
    end

    // Address presented on the current-vector word.
    assign cur_vec = hit_any ? slot_addr_q[win] : def_q;

    // Claim on matching read, release lowest set bit on end of service.
    always_ff @(posedge clk) begin
        if (!rst_n)
            svc_q <= '0;
        else if (vec_rd && hit_any)
            svc_q[win] <= 1'b1;
        else if (vec_ack)
            svc_q <= svc_q & (svc_q - NSLOT'(1));
    end
endmodule

// File: rtl/vecirq_ctrl.sv
// Module: top of the vectored interrupt controller; read mux and outputs.
// Read data is combinational from the current address; side effects of a
// read happen at the clock edge ending the access.
module vecirq_ctrl
    import vecirq_pkg::*;
#(
    parameter int unsigned NSRC    = 32,
    parameter int unsigned NSLOT   = 16,
    parameter int unsigned VAW     = 32,
    parameter logic [31:0] CELL_ID = 32'h0005A1C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int unsigned SELW = $clog2(NSRC);
    localparam int unsigned SIW  = $clog2(NSLOT);

    logic [NSRC-1:0]           sel_q;
    logic [NSRC-1:0]           en_q;
    logic [NSRC-1:0]           soft_q;
    logic                      prot_q;
    logic [VAW-1:0]            def_q;
    logic [NSLOT-1:0][VAW-1:0] slot_addr_q;
    logic [NSLOT-1:0][SELW:0]  slot_ctrl_q;
    logic                      vec_rd;
    logic                      vec_ack;
    logic [NSRC-1:0]           irq_stat;
    logic [NSRC-1:0]           fiq_stat;
    logic [VAW-1:0]            cur_vec;
    logic                      hit_any;
    logic [NSLOT-1:0]          svc_q;
    logic                      slot_in_range;

    vecirq_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .VAW(VAW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .sel_q(sel_q), .en_q(en_q), .soft_q(soft_q), .prot_q(prot_q),
        .def_q(def_q), .slot_addr_q(slot_addr_q), .slot_ctrl_q(slot_ctrl_q),
        .vec_rd(vec_rd), .vec_ack(vec_ack)
    );

    vecirq_route #(.NSRC(NSRC)) u_route (
        .src_i(src_i), .soft_q(soft_q), .en_q(en_q), .sel_q(sel_q),
        .irq_stat(irq_stat), .fiq_stat(fiq_stat)
    );

    vecirq_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .VAW(VAW)) u_prio (
        .clk(clk), .rst_n(rst_n), .irq_stat(irq_stat),
        .slot_addr_q(slot_addr_q), .slot_ctrl_q(slot_ctrl_q), .def_q(def_q),
        .vec_rd(vec_rd), .vec_ack(vec_ack),
        .cur_vec(cur_vec), .hit_any(hit_any), .svc_q(svc_q)
    );

    // Processor request lines.
    assign irq_o = |irq_stat;
    assign fiq_o = |fiq_stat;

    // Slot word index lies within the implemented slots.
    assign slot_in_range = (int'(bus_addr[7:2]) < NSLOT) && (bus_addr[1:0] == 2'b00);

    // Read data selection by address.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_IRQ_STAT)
            bus_rdata[NSRC-1:0] = irq_stat;
        else if (bus_addr == OFF_FIQ_STAT)
            bus_rdata[NSRC-1:0] = fiq_stat;
        else if (bus_addr == OFF_SELECT)
            bus_rdata[NSRC-1:0] = sel_q;
        else if (bus_addr == OFF_EN_SET)
            bus_rdata[NSRC-1:0] = en_q;
        else if (bus_addr == OFF_SOFT_SET)
            bus_rdata[NSRC-1:0] = soft_q;
        else if (bus_addr == OFF_PROT)
            bus_rdata[0] = prot_q;
        else if (bus_addr == OFF_CUR_VEC)
            bus_rdata[VAW-1:0] = cur_vec;
        else if (bus_addr == OFF_DEF_VEC)
            bus_rdata[VAW-1:0] = def_q;
        else if (bus_addr[11:8] == OFF_SLOT_ADDR[11:8] && slot_in_range)
            bus_rdata[VAW-1:0] = slot_addr_q[bus_addr[SIW+1:2]];
        else if (bus_addr[11:8] == OFF_SLOT_CTRL[11:8] && slot_in_range)
            bus_rdata[SELW:0] = slot_ctrl_q[bus_addr[SIW+1:2]];
        else if (bus_addr[11:4] == OFF_ID[11:4] && bus_addr[1:0] == 2'b00)
            bus_rdata[7:0] = CELL_ID[{bus_addr[3:2], 3'b000} +: 8];
    end
endmodule

// File: rtl/vecirq_chk.sv
// Module: property checker bound to the controller top.
// Assumes one-cycle accesses and synchronous interrupt lines.
module vecirq_chk
    import vecirq_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_priv,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   soft_q,
    input logic [NSRC-1:0]   sel_q,
    input logic              prot_q,
    input logic              vec_rd,
    input logic              vec_ack,
    input logic              hit_any,
    input logic [NSLOT-1:0]  svc_q
);
    logic accepted;
    logic blocked;
    assign accepted = bus_sel && bus_wr && (bus_priv || !prot_q);
    assign blocked  = bus_sel && bus_wr && !bus_priv && prot_q;

    // R2: an accepted set write ORs the written ones into the enable mask.
    assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && bus_addr == OFF_EN_SET)
        |=> (en_q == ($past(en_q) | $past(bus_wdata[NSRC-1:0]))));

    // R3: an accepted soft clear leaves every written-one bit clear.
    assert_soft_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && bus_addr == OFF_SOFT_CLR)
        |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == '0));

    // R9: a blocked write changes no control state.
    assert_protect_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> ($stable(en_q) && $stable(soft_q) && $stable(sel_q) && $stable(prot_q)));

    // R7: a matching vector read adds exactly one service level.
    assert_claim_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && hit_any) |=> ($countones(svc_q) == $countones($past(svc_q)) + 1));

    // R8: end of service with something in service removes exactly one level.
    assert_release_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && svc_q != '0) |=> ($countones(svc_q) + 1 == $countones($past(svc_q))));
endmodule

bind vecirq_ctrl vecirq_chk #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/vecirq_ctrl_tb.sv
`timescale 1ns/100ps
module vecirq_ctrl_tb;
    import vecirq_pkg::*;
    localparam int NSRC  = 32;
    localparam int NSLOT = 16;
    localparam logic [31:0] CELL = 32'h0005A1C3;
    localparam logic [31:0] DEFV = 32'h0000DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_r = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vecirq_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .VAW(32), .CELL_ID(CELL)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_r),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = p; bus_addr = a; bus_wdata = d;
        @(posedge clk); #0.5;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #0.5;
        bus_sel = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_hw(input logic [31:0] h);
        @(negedge clk);
        src_r = h;
    endtask

    function automatic int slot_src(input int n);
        return (n * 7 + 3) % 32;
    endfunction

    function automatic logic [31:0] slot_adr(input int n);
        return 32'h1000 + 32'(n) * 32'h10;
    endfunction

    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, acc, en, so, se, hw, id;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        rchk("R1 irq_stat", OFF_IRQ_STAT, 0);
        rchk("R1 fiq_stat", OFF_FIQ_STAT, 0);
        rchk("R1 select", OFF_SELECT, 0);
        rchk("R1 enable", OFF_EN_SET, 0);
        rchk("R1 soft", OFF_SOFT_SET, 0);
        rchk("R1 prot", OFF_PROT, 0);
        rchk("R1 default", OFF_DEF_VEC, 0);
        rchk("R1 curvec", OFF_CUR_VEC, 0);
        chk("R1 irq_o", {31'b0, irq_o}, 0);
        chk("R1 fiq_o", {31'b0, fiq_o}, 0);

        // R10: identification bytes
        id = 0;
        for (int k = 0; k < 4; k++) begin
            rd(OFF_ID + 12'(4 * k), v);
            chk("R10 id word", v, {24'b0, CELL[8*k +: 8]});
            id = id | (v << (8 * k));
        end
        chk("R10 vendor", {24'b0, id[19:12]}, 32'h5A);

        // R2: enable set sweep, zero write, clear pattern
        acc = 0;
        for (int i = 0; i < NSRC; i++) begin
            wr(OFF_EN_SET, 32'h1 << i);
            acc = acc | (32'h1 << i);
            rchk("R2 enable set", OFF_EN_SET, acc);
        end
        wr(OFF_EN_SET, 0);
        rchk("R2 zero set write", OFF_EN_SET, 32'hFFFFFFFF);
        wr(OFF_EN_CLR, 0);
        rchk("R2 zero clr write", OFF_EN_SET, 32'hFFFFFFFF);
        wr(OFF_EN_CLR, 32'hAAAA5555);
        rchk("R2 enable clear", OFF_EN_SET, 32'h5555AAAA);

        // R3: soft set sweep, zero write, clear pattern
        acc = 0;
        for (int i = 0; i < NSRC; i++) begin
            wr(OFF_SOFT_SET, 32'h1 << i);
            acc = acc | (32'h1 << i);
            rchk("R3 soft set", OFF_SOFT_SET, acc);
        end
        wr(OFF_SOFT_CLR, 0);
        rchk("R3 zero clr write", OFF_SOFT_SET, 32'hFFFFFFFF);
        wr(OFF_SOFT_CLR, 32'h0F0F33CC);
        rchk("R3 soft clear", OFF_SOFT_SET, 32'hF0F0CC33);

        // R4: routing and masking under varied patterns
        for (int k = 0; k < 12; k++) begin
            logic [31:0] ei, ef;
            en = 32'h9E3779B9 * 32'(k + 1);
            so = (32'h7F4A7C15 * 32'(k + 3)) & 32'h0F0F0F0F;
            se = 32'hC2B2AE35 * 32'(k + 5);
            hw = 32'h165667B1 * 32'(k + 7);
            if (k == 0) begin en = 0; end
            if (k == 1) begin se = 32'hFFFFFFFF; end
            if (k == 2) begin se = 0; hw = 0; so = 0; end
            wr(OFF_EN_SET, en); wr(OFF_EN_CLR, ~en);
            wr(OFF_SOFT_SET, so); wr(OFF_SOFT_CLR, ~so);
            wr(OFF_SELECT, se);
            set_hw(hw);
            ei = (hw | so) & en & ~se;
            ef = (hw | so) & en & se;
            rchk("R4 irq status", OFF_IRQ_STAT, ei);
            rchk("R4 fiq status", OFF_FIQ_STAT, ef);
            chk("R4 irq_o", {31'b0, irq_o}, {31'b0, ei != 0});
            chk("R4 fiq_o", {31'b0, fiq_o}, {31'b0, ef != 0});
        end

        // R5: slot programming and readback
        wr(OFF_SELECT, 0);
        wr(OFF_SOFT_CLR, 32'hFFFFFFFF);
        wr(OFF_EN_SET, 32'hFFFFFFFF);
        set_hw(0);
        wr(OFF_DEF_VEC, DEFV);
        for (int n = 0; n < NSLOT; n++) begin
            wr(OFF_SLOT_ADDR + 12'(4 * n), slot_adr(n));
            wr(OFF_SLOT_CTRL + 12'(4 * n), 32'hFFFFFFC0 | 32'h20 | 32'(slot_src(n)));
        end
        for (int n = 0; n < NSLOT; n++) begin
            rchk("R5 slot addr", OFF_SLOT_ADDR + 12'(4 * n), slot_adr(n));
            rchk("R5 slot ctrl", OFF_SLOT_CTRL + 12'(4 * n), 32'h20 | 32'(slot_src(n)));
        end

        // R6: priority among active slots
        rchk("R6 none active gives default", OFF_CUR_VEC, DEFV);
        for (int n = 0; n < NSLOT; n++) begin
            hw = 0;
            for (int k = n; k < NSLOT; k++) hw = hw | (32'h1 << slot_src(k));
            set_hw(hw);
            rchk("R6 lowest slot wins", OFF_CUR_VEC, slot_adr(n));
            wr(OFF_CUR_VEC, 0);
        end
        wr(OFF_SLOT_CTRL, 32'(slot_src(0)));
        set_hw((32'h1 << slot_src(0)) | (32'h1 << slot_src(1)));
        rchk("R6 disabled slot skipped", OFF_CUR_VEC, slot_adr(1));
        wr(OFF_CUR_VEC, 0);
        wr(OFF_SLOT_CTRL, 32'h20 | 32'(slot_src(0)));
        wr(OFF_SELECT, 32'h1 << slot_src(2));
        set_hw(32'h1 << slot_src(2));
        rchk("R6 fast source never matches", OFF_CUR_VEC, DEFV);
        wr(OFF_SELECT, 0);
        wr(OFF_SOFT_SET, 32'h1 << slot_src(4));
        set_hw(0);
        rchk("R6 soft source matches", OFF_CUR_VEC, slot_adr(4));
        wr(OFF_CUR_VEC, 0);
        wr(OFF_SOFT_CLR, 32'hFFFFFFFF);

        // R7: nesting threshold
        set_hw((32'h1 << slot_src(3)) | (32'h1 << slot_src(8)));
        rchk("R7 first claim", OFF_CUR_VEC, slot_adr(3));
        rchk("R7 lower priority blocked", OFF_CUR_VEC, DEFV);
        rchk("R7 default read keeps state", OFF_CUR_VEC, DEFV);
        set_hw((32'h1 << slot_src(1)) | (32'h1 << slot_src(3)) | (32'h1 << slot_src(8)));
        rchk("R7 higher priority nests", OFF_CUR_VEC, slot_adr(1));
        rchk("R7 inner level blocks all", OFF_CUR_VEC, DEFV);
        // R8: release in nesting order
        wr(OFF_CUR_VEC, 32'h12345678);
        rchk("R8 outer level still blocks", OFF_CUR_VEC, slot_adr(1) == 0 ? 0 : slot_adr(1));
        wr(OFF_CUR_VEC, 0);
        wr(OFF_CUR_VEC, 0);
        set_hw((32'h1 << slot_src(3)) | (32'h1 << slot_src(8)));
        rchk("R8 after release slot 3 claims", OFF_CUR_VEC, slot_adr(3));
        wr(OFF_CUR_VEC, 0);
        wr(OFF_CUR_VEC, 0);
        rchk("R8 idle release no effect", OFF_CUR_VEC, slot_adr(3));
        wr(OFF_CUR_VEC, 0);
        set_hw(0);

        // R9: protection
        wr(OFF_PROT, 1);
        rchk("R9 prot readback", OFF_PROT, 1);
        wr(OFF_EN_CLR, 32'hFFFFFFFF, 1'b0);
        rchk("R9 blocked enable clear", OFF_EN_SET, 32'hFFFFFFFF);
        wr(OFF_SELECT, 32'h00FF00FF, 1'b0);
        rchk("R9 blocked select", OFF_SELECT, 0);
        wr(OFF_PROT, 0, 1'b0);
        rchk("R9 blocked prot clear", OFF_PROT, 1);
        wr(OFF_SELECT, 32'h00FF00FF, 1'b1);
        rchk("R9 privileged write", OFF_SELECT, 32'h00FF00FF);
        wr(OFF_PROT, 0);
        wr(OFF_SELECT, 32'h0000F000, 1'b0);
        rchk("R9 unprotected user write", OFF_SELECT, 32'h0000F000);

        // R11: unmapped and test-control words
        wr(OFF_TEST, 0);
        rchk("R11 test word reads zero", OFF_TEST, 0);
        rchk("R11 hole reads zero", 12'h008, 0);
        rchk("R11 slot beyond range", OFF_SLOT_ADDR + 12'(4 * NSLOT), 0);
        rchk("R11 select unchanged", OFF_SELECT, 32'h0000F000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule